// File: doc/BRIEF.md
# Reset-Latched Configuration Register

This block holds one byte of start-up configuration in two copies. A backing byte stands in for a nonvolatile cell, and a set of working latches drives the chip. Every reset copies the backing byte into the latches. All configuration outputs come only from the latches. A bus read of the register returns the latches, while a programming write lands in the backing byte. A programmed value therefore shows on reads and outputs only after the next reset. In special test mode a write goes straight into the latches instead.

The latched byte places a 512-byte EEPROM window in the 64 KB map, enables or disables that window, and controls the watchdog enable. In the two modes that are not special (single-chip and expanded), a write is accepted only during the first 64 bus cycles after a reset, and only once per reset. Bootstrap and special test mode lift this protection. Single-chip and bootstrap modes also pin the EEPROM window to the top of the map.

Top module: `cfgreg_top`

## Requirements
- R1: A read with `rdEn`=1 at address 0x103F returns the working latches, with bit 3 and bit 1 forced to one. With `rdEn`=0, or at any other address, `rdData` is 0x00.
- R2: A power-on reset (`porN`=0) loads 0xFF into both the backing byte and the latches. Reads then return 0xFF, `copEnable` is 0, and when not forced the window is 0xF000–0xF1FF.
- R3: Each clock edge with `rstN`=0 copies the backing byte into the latches. A test-mode latch write is undone by the next reset.
- R4: In modes 00, 01 and 10, an accepted write changes neither `rdData` nor `copEnable` nor `eepromSel` until the next reset.
- R5: In mode 11 (special test), a write to 0x103F updates the latches at that clock edge, and the backing byte is left unchanged.
- R6: In modes 00 (single-chip) and 01 (expanded), a write is accepted only at clock edges 1 through 64 after `rstN` rises. A write at edge 65 or later is dropped.
- R7: In modes 00 and 01, only the first accepted write after a reset is kept. Later writes before the next reset are dropped.
- R8: In mode 10 (bootstrap), writes to the backing byte are accepted at any time and any number of times.
- R9: The window base is {EE, 12'h000}, where EE is latch bits 7:4, and the window spans 512 bytes in modes 01 and 11. In modes 00 and 10 the window is 0xFE00–0xFFFF whatever EE holds.
- R10: `eepromSel` is 1 only when latch bit 0 (EEPROM enable) is 1 and `busAddr` lies inside the window.
- R11: `copEnable` is the inverse of latch bit 2 (watchdog disable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one edge is one bus cycle |
| porN | input | 1 | Asynchronous power-on reset, active low |
| rstN | input | 1 | Synchronous system reset, active low |
| mode | input | 2 | 00 single-chip, 01 expanded, 10 bootstrap, 11 special test |
| busAddr | input | 16 | Bus address |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational |
| eepromSel | output | 1 | EEPROM window hit |
| copEnable | output | 1 | Watchdog enable |

## Verification
The protection window can close in the same cycle as a write. A write held at edge 64 after reset release must land, and one held at edge 65 must not. Both cases are provoked by counting idle cycles after releasing `rstN` and then writing. The once-per-reset flag meets the same window: a second write that arrives while the window is still open must lose to the first. Every case is judged after a later reset, by reading the value back at 0x103F.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } mode_e;

  localparam int BIT_EEON  = 0;
  localparam int BIT_NOCOP = 2;
  localparam logic [7:0] UNUSED_ONES = 8'b0000_1010;
  localparam logic [7:0] POR_VALUE   = 8'hFF;

  typedef struct packed {
    logic loadLatch;
    logic wrLatch;
    logic wrBacking;
    logic rdHit;
    logic forceMap;
  } strobe_t;

endpackage

// File: rtl/cfgreg_ctrl.sv
module cfgreg_ctrl
  import cfgreg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h103F,
  parameter int PROT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  output strobe_t           strb
);
  localparam int CNT_W = $clog2(PROT_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PROT_CYCLES);

  logic [CNT_W-1:0] cycleCnt;
  logic             written;
  logic             cfgHit;
  logic             wrHit;
  logic             isSpecial;
  logic             protOpen;
  logic             protAccept;

  assign cfgHit     = (busAddr == CFG_ADDR);
  assign wrHit      = rstN && wrEn && cfgHit;
  assign isSpecial  = (mode == MODE_BOOT) || (mode == MODE_TEST);
  assign protOpen   = (cycleCnt < CNT_MAX) && !written;
  assign protAccept = wrHit && !isSpecial && protOpen;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cycleCnt <= '0;
      written  <= 1'b0;
    end else if (!rstN) begin
      cycleCnt <= '0;
      written  <= 1'b0;
    end else begin
      if (cycleCnt != CNT_MAX) cycleCnt <= cycleCnt + 1'b1;
      if (protAccept) written <= 1'b1;
    end
  end

  always_comb begin
    strb.loadLatch = !rstN;
    strb.wrLatch   = wrHit && (mode == MODE_TEST);
    strb.wrBacking = protAccept || (wrHit && (mode == MODE_BOOT));
    strb.rdHit     = rdEn && cfgHit;
    strb.forceMap  = (mode == MODE_SINGLE) || (mode == MODE_BOOT);
  end

endmodule

// File: rtl/cfgreg_dp.sv
module cfgreg_dp
  import cfgreg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_BITS = 9,
  parameter logic [ADDR_W-1:0] FORCED_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              porN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              eepromSel,
  output logic              copEnable
);
  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic [7:0]        backing;
  logic [7:0]        latches;
  logic [ADDR_W-1:0] winBase;
  logic              inWin;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) backing <= POR_VALUE;
    else if (strb.wrBacking) backing <= wrData;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) latches <= POR_VALUE;
    else if (strb.loadLatch) latches <= backing;
    else if (strb.wrLatch) latches <= wrData;
  end

  assign winBase = strb.forceMap ? FORCED_BASE
                                 : {latches[7:4], {(ADDR_W-4){1'b0}}};
  assign inWin   = (busAddr[ADDR_W-1 -: TAG_W] == winBase[ADDR_W-1 -: TAG_W]);

  assign eepromSel = latches[BIT_EEON] && inWin;
  assign copEnable = !latches[BIT_NOCOP];
  assign rdData    = strb.rdHit ? (latches | UNUSED_ONES) : 8'h00;

endmodule

// File: rtl/cfgreg_top.sv
module cfgreg_top
  import cfgreg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h103F,
  parameter int PROT_CYCLES = 64,
  parameter int WIN_BITS = 9,
  parameter logic [ADDR_W-1:0] FORCED_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              eepromSel,
  output logic              copEnable
);
  strobe_t strb;

  cfgreg_ctrl #(
    .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .PROT_CYCLES(PROT_CYCLES)
  ) ctrl_i (
    .clk(clk), .porN(porN), .rstN(rstN), .mode(mode),
    .busAddr(busAddr), .rdEn(rdEn), .wrEn(wrEn), .strb(strb)
  );

  cfgreg_dp #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .FORCED_BASE(FORCED_BASE)
  ) dp_i (
    .clk(clk), .porN(porN), .strb(strb), .busAddr(busAddr),
    .wrData(wrData), .rdData(rdData), .eepromSel(eepromSel),
    .copEnable(copEnable)
  );

endmodule

// File: rtl/cfgreg_chk.sv
module cfgreg_chk (
  input logic        clk,
  input logic        porN,
  input logic        rstN,
  input logic [1:0]  mode,
  input logic [15:0] busAddr,
  input logic        rdEn,
  input logic        wrEn,
  input logic [7:0]  wrData,
  input logic [7:0]  rdData,
  input logic        eepromSel,
  input logic        copEnable
);
  AST_READ_ONES: assert property (@(posedge clk) disable iff (!porN)
    (rdEn && busAddr == 16'h103F) |-> (rdData[3] && rdData[1])); // R1

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!porN)
    !rdEn |-> (rdData == 8'h00)); // R1

  AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (!porN)
    (rstN && $past(rstN) && mode != 2'b11 && $past(mode) != 2'b11)
      |-> $stable(copEnable)); // R4

  AST_TEST_WRITE: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (mode == 2'b11 && wrEn && busAddr == 16'h103F)
      |=> (copEnable == !$past(wrData[2]))); // R5

  AST_FORCED_WIN: assert property (@(posedge clk) disable iff (!porN)
    (eepromSel && (mode == 2'b00 || mode == 2'b10))
      |-> (busAddr[15:9] == 7'h7F)); // R9

endmodule

bind cfgreg_top cfgreg_chk chk_i (
  .clk(clk), .porN(porN), .rstN(rstN), .mode(mode), .busAddr(busAddr),
  .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .eepromSel(eepromSel), .copEnable(copEnable)
);

// File: tb/cfgreg_top_tb_top.sv
module cfgreg_top_tb_top;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic [15:0] busAddr = 16'h0000;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic        eepromSel;
  logic        copEnable;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfgreg_top dut_i (
    .clk(clk), .porN(porN), .rstN(rstN), .mode(mode), .busAddr(busAddr),
    .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .eepromSel(eepromSel), .copEnable(copEnable)
  );

  typedef struct packed {
    logic [1:0]  m;
    logic [7:0]  lat;
    logic [15:0] a;
    logic        sel;
    logic        cop;
    logic [7:0]  rd;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{2'd1, 8'h5D, 16'h5000, 1'b1, 1'b0, 8'h5F},
    '{2'd1, 8'h5D, 16'h51FF, 1'b1, 1'b0, 8'h5F},
    '{2'd1, 8'h5D, 16'h5200, 1'b0, 1'b0, 8'h5F},
    '{2'd0, 8'h5D, 16'h5000, 1'b0, 1'b0, 8'h5F},
    '{2'd0, 8'h5D, 16'hFE00, 1'b1, 1'b0, 8'h5F},
    '{2'd2, 8'h5D, 16'hFFFF, 1'b1, 1'b0, 8'h5F},
    '{2'd1, 8'h5C, 16'h5000, 1'b0, 1'b0, 8'h5E},
    '{2'd3, 8'hA1, 16'hA1FF, 1'b1, 1'b1, 8'hAB},
    '{2'd2, 8'hA1, 16'hFDFF, 1'b0, 1'b1, 8'hAB},
    '{2'd1, 8'hA1, 16'hFE00, 1'b0, 1'b1, 8'hAB}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge; the write lands at the next posedge.
  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCfg(output logic [7:0] v);
    busAddr = 16'h103F; rdEn = 1'b1;
    #1 v = rdData;
    rdEn = 1'b0;
  endtask

  task automatic doReset;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (2) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);
    doReset;

    // R2: power-on state
    readCfg(v);               check("R2 por read", 16'(v), 16'h00FF);
    check("R2 cop off", 16'(copEnable), 16'h0);
    mode = 2'b01; busAddr = 16'hF000; rdEn = 1'b0;
    #1 check("R2 window F000", 16'(eepromSel), 16'h1);
    busAddr = 16'hFE00;
    #1 check("R2 unforced FE00 miss", 16'(eepromSel), 16'h0);

    // R1: idle and wrong-address reads
    busAddr = 16'h103F; rdEn = 1'b0;
    #1 check("R1 no strobe", 16'(rdData), 16'h0);
    busAddr = 16'h103E; rdEn = 1'b1;
    #1 check("R1 other addr", 16'(rdData), 16'h0);
    rdEn = 1'b0;

    // R4 / R3 / R6: early write in expanded mode
    @(negedge clk);
    doReset;
    busWrite(16'h103F, 8'h31);
    readCfg(v);               check("R4 not visible", 16'(v), 16'h00FF);
    check("R4 cop held", 16'(copEnable), 16'h0);
    doReset;
    readCfg(v);               check("R3 reset load", 16'(v), 16'h003B);
    check("R11 cop on", 16'(copEnable), 16'h1);

    // R7: second write in open window dropped
    @(negedge clk);
    doReset;
    busWrite(16'h103F, 8'h41);
    busWrite(16'h103F, 8'h52);
    doReset;
    readCfg(v);               check("R7 first write kept", 16'(v), 16'h004B);

    // R6: edge 64 accepted, edge 65 dropped
    @(negedge clk);
    doReset;
    repeat (63) @(negedge clk);
    busWrite(16'h103F, 8'h61);
    doReset;
    readCfg(v);               check("R6 edge 64 accepted", 16'(v), 16'h006B);
    @(negedge clk);
    doReset;
    repeat (64) @(negedge clk);
    busWrite(16'h103F, 8'h71);
    doReset;
    readCfg(v);               check("R6 edge 65 dropped", 16'(v), 16'h006B);

    // R8: bootstrap overrides protection
    mode = 2'b10;
    @(negedge clk);
    doReset;
    repeat (100) @(negedge clk);
    busWrite(16'h103F, 8'h81);
    busWrite(16'h103F, 8'h93);
    readCfg(v);               check("R4 bootstrap not visible", 16'(v), 16'h006B);
    doReset;
    readCfg(v);               check("R8 late repeated write", 16'(v), 16'h009B);

    // R5 / R3: test mode writes latches only
    mode = 2'b11;
    @(negedge clk);
    busWrite(16'h103F, 8'h05);
    readCfg(v);               check("R5 direct latch", 16'(v), 16'h000F);
    check("R5 cop follows", 16'(copEnable), 16'h0);
    doReset;
    readCfg(v);               check("R3 backing untouched", 16'(v), 16'h009B);

    // R9 / R10 / R11: table walk
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      mode = 2'b11;
      busWrite(16'h103F, VEC[i].lat);
      mode = VEC[i].m;
      busAddr = VEC[i].a;
      #1 check($sformatf("R9 R10 sel vec%0d", i), 16'(eepromSel), 16'(VEC[i].sel));
      check($sformatf("R11 cop vec%0d", i), 16'(copEnable), 16'(VEC[i].cop));
      readCfg(v);
      check($sformatf("R1 read vec%0d", i), 16'(v), 16'(VEC[i].rd));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule